// File: doc/BRIEF.md
# Dual-Clock Bidirectional Word Buffer with Cross-Port Mailboxes

This block sits between a processor and a mezzanine module and carries 32-bit words in both directions through two separate 64-word queues. The inbound queue is filled from the mezzanine side and emptied by the processor. The outbound queue runs the other way. The two sides run on unrelated clocks. The mezzanine clock may be steady, irregular or bursty, because only the clock edges on which the select input is high move any data.

The mezzanine side has a single logical data bus. A direction input picks whether a selected edge pushes the incoming word into the inbound queue or pops the next outbound word onto the read bus. An output enable is provided for the pad driver. Queue pointers cross between the clock domains as Gray codes through two-flop synchronisers. As a result, full and empty assert as soon as the local side causes them and clear a few cycles after the far side acts. The processor programs the almost-empty and almost-full distances, and both sides see the resulting flags.

Two mailbox registers let each side send a single word to the other. A mailbox write raises an interrupt on the far port. That interrupt stays high until the receiving side reads the mailbox. An asynchronous reset, owned by the mezzanine side, empties both queues.

Top module: `bififo_mbx`

## Requirements
- R1: A mezzanine edge with mezzSel=1, mezzDir=1, mezzMbx=0 pushes mezzWData into the inbound queue. Each processor edge with procFifoRd=1 pops the oldest word, which appears on procRData after that edge, in first-in first-out order.
- R2: A processor edge with procFifoWr=1 pushes procWData into the outbound queue. A mezzanine edge with mezzSel=1, mezzDir=0, mezzMbx=0 pops the oldest word onto mezzRData after that edge. mezzDataOe is 1 while mezzDir=0 and 0 while mezzDir=1.
- R3: A mezzanine edge with mezzSel=0 moves no data: queue levels and mezzRData are unchanged.
- R4: Each queue holds 64 words. Full asserts right after the 64th accepted push. A push while full is dropped and leaves exactly the 64 stored words.
- R5: A mezzanine read while mezzOutEmpty=1 is ignored: mezzRData keeps the last word read, and no pointer moves.
- R6: With the reset thresholds of 8, a queue flags almost-empty when it holds 8 words or fewer and almost-full when it holds 56 words or more. The flags appear on both ports, and an empty queue always reads as almost-empty.
- R7: A processor edge with procCfgWr=1 loads procWData[6:0] as the almost-empty threshold when procCfgSel=0, or as the almost-full distance from full when procCfgSel=1. Both sides' flags then follow the new value, and stored words are untouched.
- R8: A mezzanine edge with mezzSel=1, mezzDir=1, mezzMbx=1 loads mezzWData into the inbound mailbox and not into the queue. procMbxIrq rises within 8 processor cycles. A processor edge with procMbxRd=1 puts the mailbox word on procRData and clears procMbxIrq.
- R9: A processor edge with procMbxWr=1 loads procWData into the outbound mailbox and raises mezzMbxIrq. A mezzanine edge with mezzSel=1, mezzDir=0, mezzMbx=1 puts that word on mezzRData and clears mezzMbxIrq.
- R10: rstN=0 empties both queues, clears both interrupts and restores both thresholds to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| procClk | input | 1 | Processor-side clock |
| mezzClk | input | 1 | Mezzanine-side clock |
| rstN | input | 1 | Asynchronous active-low reset that clears queues, mailboxes and thresholds |
| procFifoWr | input | 1 | Push procWData into the outbound queue |
| procFifoRd | input | 1 | Pop the inbound queue onto procRData |
| procMbxWr | input | 1 | Load the outbound mailbox from procWData |
| procMbxRd | input | 1 | Read the inbound mailbox and clear procMbxIrq |
| procCfgWr | input | 1 | Load a threshold from procWData[6:0] |
| procCfgSel | input | 1 | 0 selects the almost-empty threshold, 1 selects the almost-full distance |
| procWData | input | 32 | Processor write data |
| procRData | output | 32 | Processor read data, registered |
| procInEmpty | output | 1 | Inbound queue empty (processor view) |
| procInAlmostEmpty | output | 1 | Inbound queue almost empty (processor view) |
| procInAlmostFull | output | 1 | Inbound queue almost full (processor view) |
| procOutFull | output | 1 | Outbound queue full (processor view) |
| procOutAlmostFull | output | 1 | Outbound queue almost full (processor view) |
| procOutAlmostEmpty | output | 1 | Outbound queue almost empty (processor view) |
| procMbxIrq | output | 1 | Inbound mailbox holds an unread word |
| mezzSel | input | 1 | Qualifies the mezzanine clock edge |
| mezzDir | input | 1 | 1 = write toward the processor, 0 = read from the processor |
| mezzMbx | input | 1 | Steers the access to the mailbox instead of the queue |
| mezzWData | input | 32 | Inbound half of the shared mezzanine bus |
| mezzRData | output | 32 | Outbound half of the shared mezzanine bus, registered |
| mezzDataOe | output | 1 | Drive enable for the shared bus pads |
| mezzInFull | output | 1 | Inbound queue full (mezzanine view) |
| mezzInAlmostFull | output | 1 | Inbound queue almost full (mezzanine view) |
| mezzInAlmostEmpty | output | 1 | Inbound queue almost empty (mezzanine view) |
| mezzOutEmpty | output | 1 | Outbound queue empty (mezzanine view) |
| mezzOutAlmostEmpty | output | 1 | Outbound queue almost empty (mezzanine view) |
| mezzOutAlmostFull | output | 1 | Outbound queue almost full (mezzanine view) |
| mezzMbxIrq | output | 1 | Outbound mailbox holds an unread word |

## Verification
Read data and the flags of the side that made an access update at that same clock edge. The bench therefore samples them at the falling edge that follows. Any flag, threshold or interrupt that must cross to the other clock takes up to three or four cycles of the receiving clock. The bench waits eight cycles of each clock before it compares those results. A behavioural queue model predicts every popped word, and each result is compared with that model at its own fixed sampling point.

// File: rtl/bififo_pkg.sv
`timescale 1ns/1ps
package bififo_pkg;
  // One-cycle strobes issued by control, consumed by the datapath.
  typedef struct packed {
    logic inPush;       // mezz domain
    logic inPop;        // proc domain
    logic outPush;      // proc domain
    logic outPop;       // mezz domain
    logic mbxToProcLd;  // mezz domain
    logic mbxToMezzLd;  // proc domain
    logic procRdMbx;    // proc domain
    logic mezzRdMbx;    // mezz domain
  } strobe_t;
endpackage

// File: rtl/bififo_ptrs.sv
`timescale 1ns/1ps
module bififo_ptrs #(
  parameter int AW = 6
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrReq,
  input  logic [AW:0]   wrAeThr,
  input  logic [AW:0]   wrAfThr,
  output logic          wrAccept,
  output logic [AW-1:0] wrAddr,
  output logic          wrFull,
  output logic          wrAlmostFull,
  output logic          wrAlmostEmpty,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdReq,
  input  logic [AW:0]   rdAeThr,
  input  logic [AW:0]   rdAfThr,
  output logic          rdAccept,
  output logic [AW-1:0] rdAddr,
  output logic          rdEmpty,
  output logic          rdAlmostEmpty,
  output logic          rdAlmostFull
);
  localparam logic [AW:0]   FULL_LVL = (AW+1)'(1) << AW;
  localparam logic [AW+1:0] FULL_EXT = {1'b0, FULL_LVL};

  logic [AW:0] wrBin, wrGray, rdBin, rdGray;
  logic [AW:0] rdGrayMeta, rdGraySync, wrGrayMeta, wrGraySync;
  logic [AW:0] wrBinNext, rdBinNext, wrLvl, rdLvl;

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  assign wrLvl     = wrBin - gray2bin(rdGraySync);
  assign wrFull    = (wrLvl == FULL_LVL);
  assign wrAccept  = wrReq & ~wrFull;
  assign wrBinNext = wrBin + (AW+1)'(wrAccept);
  assign wrAddr    = wrBin[AW-1:0];
  assign wrAlmostEmpty = (wrLvl <= wrAeThr);
  assign wrAlmostFull  = (({1'b0, wrLvl} + {1'b0, wrAfThr}) >= FULL_EXT);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      rdGrayMeta <= '0;
      rdGraySync <= '0;
    end else begin
      wrBin      <= wrBinNext;
      wrGray     <= wrBinNext ^ (wrBinNext >> 1);
      rdGrayMeta <= rdGray;
      rdGraySync <= rdGrayMeta;
    end
  end

  // read side
  assign rdLvl     = gray2bin(wrGraySync) - rdBin;
  assign rdEmpty   = (rdLvl == '0);
  assign rdAccept  = rdReq & ~rdEmpty;
  assign rdBinNext = rdBin + (AW+1)'(rdAccept);
  assign rdAddr    = rdBin[AW-1:0];
  assign rdAlmostEmpty = (rdLvl <= rdAeThr);
  assign rdAlmostFull  = (({1'b0, rdLvl} + {1'b0, rdAfThr}) >= FULL_EXT);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin      <= '0;
      rdGray     <= '0;
      wrGrayMeta <= '0;
      wrGraySync <= '0;
    end else begin
      rdBin      <= rdBinNext;
      rdGray     <= rdBinNext ^ (rdBinNext >> 1);
      wrGrayMeta <= wrGray;
      wrGraySync <= wrGrayMeta;
    end
  end
endmodule

// File: rtl/bififo_ctrl.sv
`timescale 1ns/1ps
module bififo_ctrl
  import bififo_pkg::*;
#(
  parameter int AW        = 6,
  parameter int RESET_THR = 8
) (
  input  logic          procClk,
  input  logic          mezzClk,
  input  logic          rstN,
  output logic          procRstN,
  output logic          mezzRstN,
  input  logic          procFifoWr,
  input  logic          procFifoRd,
  input  logic          procMbxWr,
  input  logic          procMbxRd,
  input  logic          procCfgWr,
  input  logic          procCfgSel,
  input  logic [AW:0]   procCfgVal,
  input  logic          mezzSel,
  input  logic          mezzDir,
  input  logic          mezzMbx,
  output strobe_t       stb,
  output logic [AW-1:0] inWrAddr,
  output logic [AW-1:0] inRdAddr,
  output logic [AW-1:0] outWrAddr,
  output logic [AW-1:0] outRdAddr,
  output logic          procInEmpty,
  output logic          procInAlmostEmpty,
  output logic          procInAlmostFull,
  output logic          procOutFull,
  output logic          procOutAlmostFull,
  output logic          procOutAlmostEmpty,
  output logic          procMbxIrq,
  output logic          mezzDataOe,
  output logic          mezzInFull,
  output logic          mezzInAlmostFull,
  output logic          mezzInAlmostEmpty,
  output logic          mezzOutEmpty,
  output logic          mezzOutAlmostEmpty,
  output logic          mezzOutAlmostFull,
  output logic          mezzMbxIrq
);
  localparam logic [AW:0] THR_INIT = (AW+1)'(RESET_THR);

  logic [1:0] procRstSh, mezzRstSh;
  logic [AW:0] aeThr, afThr, mezzAeMeta, mezzAeThr, mezzAfMeta, mezzAfThr;
  logic mezzWrQ, mezzRdQ, mezzWrM, mezzRdM;
  logic inPushOk, inPopOk, outPushOk, outPopOk;
  logic mezzTgl, procTgl;
  logic [2:0] procSeeTgl, mezzSeeTgl;

  // reset synchronisers: asynchronous assert, synchronous release
  always_ff @(posedge procClk or negedge rstN)
    if (!rstN) procRstSh <= 2'b00;
    else       procRstSh <= {procRstSh[0], 1'b1};
  always_ff @(posedge mezzClk or negedge rstN)
    if (!rstN) mezzRstSh <= 2'b00;
    else       mezzRstSh <= {mezzRstSh[0], 1'b1};
  assign procRstN = procRstSh[1];
  assign mezzRstN = mezzRstSh[1];

  // mezzanine access decode
  assign mezzWrQ    = mezzSel &  mezzDir & ~mezzMbx;
  assign mezzRdQ    = mezzSel & ~mezzDir & ~mezzMbx;
  assign mezzWrM    = mezzSel &  mezzDir &  mezzMbx;
  assign mezzRdM    = mezzSel & ~mezzDir &  mezzMbx;
  assign mezzDataOe = ~mezzDir;

  // threshold registers (processor domain) and their mezzanine copies
  always_ff @(posedge procClk or negedge procRstN) begin
    if (!procRstN) begin
      aeThr <= THR_INIT;
      afThr <= THR_INIT;
    end else if (procCfgWr) begin
      if (procCfgSel) afThr <= procCfgVal;
      else            aeThr <= procCfgVal;
    end
  end

  always_ff @(posedge mezzClk or negedge mezzRstN) begin
    if (!mezzRstN) begin
      mezzAeMeta <= THR_INIT;
      mezzAeThr  <= THR_INIT;
      mezzAfMeta <= THR_INIT;
      mezzAfThr  <= THR_INIT;
    end else begin
      mezzAeMeta <= aeThr;
      mezzAeThr  <= mezzAeMeta;
      mezzAfMeta <= afThr;
      mezzAfThr  <= mezzAfMeta;
    end
  end

  // inbound queue: mezzanine writes, processor reads
  bififo_ptrs #(.AW(AW)) u_inPtrs (
    .wrClk(mezzClk), .wrRstN(mezzRstN), .wrReq(mezzWrQ),
    .wrAeThr(mezzAeThr), .wrAfThr(mezzAfThr),
    .wrAccept(inPushOk), .wrAddr(inWrAddr), .wrFull(mezzInFull),
    .wrAlmostFull(mezzInAlmostFull), .wrAlmostEmpty(mezzInAlmostEmpty),
    .rdClk(procClk), .rdRstN(procRstN), .rdReq(procFifoRd),
    .rdAeThr(aeThr), .rdAfThr(afThr),
    .rdAccept(inPopOk), .rdAddr(inRdAddr), .rdEmpty(procInEmpty),
    .rdAlmostEmpty(procInAlmostEmpty), .rdAlmostFull(procInAlmostFull)
  );

  // outbound queue: processor writes, mezzanine reads
  bififo_ptrs #(.AW(AW)) u_outPtrs (
    .wrClk(procClk), .wrRstN(procRstN), .wrReq(procFifoWr),
    .wrAeThr(aeThr), .wrAfThr(afThr),
    .wrAccept(outPushOk), .wrAddr(outWrAddr), .wrFull(procOutFull),
    .wrAlmostFull(procOutAlmostFull), .wrAlmostEmpty(procOutAlmostEmpty),
    .rdClk(mezzClk), .rdRstN(mezzRstN), .rdReq(mezzRdQ),
    .rdAeThr(mezzAeThr), .rdAfThr(mezzAfThr),
    .rdAccept(outPopOk), .rdAddr(outRdAddr), .rdEmpty(mezzOutEmpty),
    .rdAlmostEmpty(mezzOutAlmostEmpty), .rdAlmostFull(mezzOutAlmostFull)
  );

  // mailbox events cross as toggles; the receiving side holds the interrupt
  always_ff @(posedge mezzClk or negedge mezzRstN)
    if (!mezzRstN)    mezzTgl <= 1'b0;
    else if (mezzWrM) mezzTgl <= ~mezzTgl;

  always_ff @(posedge procClk or negedge procRstN)
    if (!procRstN)      procTgl <= 1'b0;
    else if (procMbxWr) procTgl <= ~procTgl;

  always_ff @(posedge procClk or negedge procRstN) begin
    if (!procRstN) begin
      procSeeTgl <= '0;
      procMbxIrq <= 1'b0;
    end else begin
      procSeeTgl <= {procSeeTgl[1:0], mezzTgl};
      if (procSeeTgl[2] ^ procSeeTgl[1]) procMbxIrq <= 1'b1;
      else if (procMbxRd)                procMbxIrq <= 1'b0;
    end
  end

  always_ff @(posedge mezzClk or negedge mezzRstN) begin
    if (!mezzRstN) begin
      mezzSeeTgl <= '0;
      mezzMbxIrq <= 1'b0;
    end else begin
      mezzSeeTgl <= {mezzSeeTgl[1:0], procTgl};
      if (mezzSeeTgl[2] ^ mezzSeeTgl[1]) mezzMbxIrq <= 1'b1;
      else if (mezzRdM)                  mezzMbxIrq <= 1'b0;
    end
  end

  always_comb begin
    stb             = '0;
    stb.inPush      = inPushOk;
    stb.inPop       = inPopOk;
    stb.outPush     = outPushOk;
    stb.outPop      = outPopOk;
    stb.mbxToProcLd = mezzWrM;
    stb.mbxToMezzLd = procMbxWr;
    stb.procRdMbx   = procMbxRd & ~procFifoRd;
    stb.mezzRdMbx   = mezzRdM;
  end
endmodule

// File: rtl/bififo_dp.sv
`timescale 1ns/1ps
module bififo_dp
  import bififo_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          procClk,
  input  logic          procRstN,
  input  logic          mezzClk,
  input  logic          mezzRstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] inWrAddr,
  input  logic [AW-1:0] inRdAddr,
  input  logic [AW-1:0] outWrAddr,
  input  logic [AW-1:0] outRdAddr,
  input  logic [DW-1:0] procWData,
  input  logic [DW-1:0] mezzWData,
  output logic [DW-1:0] procRData,
  output logic [DW-1:0] mezzRData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] inMem  [DEPTH];
  logic [DW-1:0] outMem [DEPTH];
  logic [DW-1:0] mbxToProc, mbxToMezz;

  always_ff @(posedge mezzClk)
    if (stb.inPush) inMem[inWrAddr] <= mezzWData;

  always_ff @(posedge procClk)
    if (stb.outPush) outMem[outWrAddr] <= procWData;

  always_ff @(posedge mezzClk or negedge mezzRstN)
    if (!mezzRstN)            mbxToProc <= '0;
    else if (stb.mbxToProcLd) mbxToProc <= mezzWData;

  always_ff @(posedge procClk or negedge procRstN)
    if (!procRstN)            mbxToMezz <= '0;
    else if (stb.mbxToMezzLd) mbxToMezz <= procWData;

  always_ff @(posedge procClk or negedge procRstN) begin
    if (!procRstN)          procRData <= '0;
    else if (stb.inPop)     procRData <= inMem[inRdAddr];
    else if (stb.procRdMbx) procRData <= mbxToProc;
  end

  always_ff @(posedge mezzClk or negedge mezzRstN) begin
    if (!mezzRstN)          mezzRData <= '0;
    else if (stb.outPop)    mezzRData <= outMem[outRdAddr];
    else if (stb.mezzRdMbx) mezzRData <= mbxToMezz;
  end
endmodule

// File: rtl/bififo_mbx.sv
`timescale 1ns/1ps
module bififo_mbx
  import bififo_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 6,
  parameter int RESET_THR = 8
) (
  input  logic          procClk,
  input  logic          mezzClk,
  input  logic          rstN,
  input  logic          procFifoWr,
  input  logic          procFifoRd,
  input  logic          procMbxWr,
  input  logic          procMbxRd,
  input  logic          procCfgWr,
  input  logic          procCfgSel,
  input  logic [DW-1:0] procWData,
  output logic [DW-1:0] procRData,
  output logic          procInEmpty,
  output logic          procInAlmostEmpty,
  output logic          procInAlmostFull,
  output logic          procOutFull,
  output logic          procOutAlmostFull,
  output logic          procOutAlmostEmpty,
  output logic          procMbxIrq,
  input  logic          mezzSel,
  input  logic          mezzDir,
  input  logic          mezzMbx,
  input  logic [DW-1:0] mezzWData,
  output logic [DW-1:0] mezzRData,
  output logic          mezzDataOe,
  output logic          mezzInFull,
  output logic          mezzInAlmostFull,
  output logic          mezzInAlmostEmpty,
  output logic          mezzOutEmpty,
  output logic          mezzOutAlmostEmpty,
  output logic          mezzOutAlmostFull,
  output logic          mezzMbxIrq
);
  strobe_t stb;
  logic procRstN, mezzRstN;
  logic [AW-1:0] inWrAddr, inRdAddr, outWrAddr, outRdAddr;

  bififo_ctrl #(.AW(AW), .RESET_THR(RESET_THR)) u_ctrl (
    .procClk(procClk), .mezzClk(mezzClk), .rstN(rstN),
    .procRstN(procRstN), .mezzRstN(mezzRstN),
    .procFifoWr(procFifoWr), .procFifoRd(procFifoRd),
    .procMbxWr(procMbxWr), .procMbxRd(procMbxRd),
    .procCfgWr(procCfgWr), .procCfgSel(procCfgSel),
    .procCfgVal(procWData[AW:0]),
    .mezzSel(mezzSel), .mezzDir(mezzDir), .mezzMbx(mezzMbx),
    .stb(stb),
    .inWrAddr(inWrAddr), .inRdAddr(inRdAddr),
    .outWrAddr(outWrAddr), .outRdAddr(outRdAddr),
    .procInEmpty(procInEmpty), .procInAlmostEmpty(procInAlmostEmpty),
    .procInAlmostFull(procInAlmostFull), .procOutFull(procOutFull),
    .procOutAlmostFull(procOutAlmostFull), .procOutAlmostEmpty(procOutAlmostEmpty),
    .procMbxIrq(procMbxIrq), .mezzDataOe(mezzDataOe),
    .mezzInFull(mezzInFull), .mezzInAlmostFull(mezzInAlmostFull),
    .mezzInAlmostEmpty(mezzInAlmostEmpty), .mezzOutEmpty(mezzOutEmpty),
    .mezzOutAlmostEmpty(mezzOutAlmostEmpty), .mezzOutAlmostFull(mezzOutAlmostFull),
    .mezzMbxIrq(mezzMbxIrq)
  );

  bififo_dp #(.DW(DW), .AW(AW)) u_dp (
    .procClk(procClk), .procRstN(procRstN),
    .mezzClk(mezzClk), .mezzRstN(mezzRstN),
    .stb(stb),
    .inWrAddr(inWrAddr), .inRdAddr(inRdAddr),
    .outWrAddr(outWrAddr), .outRdAddr(outRdAddr),
    .procWData(procWData), .mezzWData(mezzWData),
    .procRData(procRData), .mezzRData(mezzRData)
  );
endmodule

// File: rtl/bififo_chk.sv
`timescale 1ns/1ps
module bififo_chk #(
  parameter int DW = 32
) (
  input logic          procClk,
  input logic          mezzClk,
  input logic          rstN,
  input logic          procFifoRd,
  input logic          procMbxRd,
  input logic [DW-1:0] procRData,
  input logic          procInEmpty,
  input logic          procInAlmostEmpty,
  input logic          mezzSel,
  input logic          mezzDir,
  input logic          mezzMbx,
  input logic [DW-1:0] mezzRData,
  input logic          mezzInFull,
  input logic          mezzInAlmostFull,
  input logic          mezzOutEmpty,
  input logic          mezzOutAlmostEmpty
);
  // R1: processor read data only moves on a processor read
  p_proc_rdata_hold_r1: assert property (@(posedge procClk) disable iff (!rstN)
    (!procFifoRd && !procMbxRd) |=> $stable(procRData));

  // R3: an unselected mezzanine edge leaves the read bus alone
  p_unselected_idle_r3: assert property (@(posedge mezzClk) disable iff (!rstN)
    !mezzSel |=> $stable(mezzRData));

  // R4: full is always inside the almost-full band
  p_full_in_af_r4: assert property (@(posedge mezzClk) disable iff (!rstN)
    mezzInFull |-> mezzInAlmostFull);

  // R5: a read of an empty outbound queue keeps the last word
  p_no_underflow_r5: assert property (@(posedge mezzClk) disable iff (!rstN)
    (mezzSel && !mezzDir && !mezzMbx && mezzOutEmpty) |=> $stable(mezzRData));

  // R6: an empty queue is always almost empty, on either side
  p_empty_is_ae_mezz_r6: assert property (@(posedge mezzClk) disable iff (!rstN)
    mezzOutEmpty |-> mezzOutAlmostEmpty);
  p_empty_is_ae_proc_r6: assert property (@(posedge procClk) disable iff (!rstN)
    procInEmpty |-> procInAlmostEmpty);
endmodule

bind bififo_mbx bififo_chk #(.DW(DW)) u_chk (
  .procClk(procClk), .mezzClk(mezzClk), .rstN(rstN),
  .procFifoRd(procFifoRd), .procMbxRd(procMbxRd), .procRData(procRData),
  .procInEmpty(procInEmpty), .procInAlmostEmpty(procInAlmostEmpty),
  .mezzSel(mezzSel), .mezzDir(mezzDir), .mezzMbx(mezzMbx),
  .mezzRData(mezzRData), .mezzInFull(mezzInFull),
  .mezzInAlmostFull(mezzInAlmostFull), .mezzOutEmpty(mezzOutEmpty),
  .mezzOutAlmostEmpty(mezzOutAlmostEmpty)
);

// File: tb/sim_bififo_mbx.sv
`timescale 1ns/1ps
module sim_bififo_mbx;
  logic procClk = 1'b0, mezzClk = 1'b0, rstN = 1'b0;
  logic procFifoWr = 0, procFifoRd = 0, procMbxWr = 0, procMbxRd = 0;
  logic procCfgWr = 0, procCfgSel = 0;
  logic [31:0] procWData = '0, procRData;
  logic procInEmpty, procInAlmostEmpty, procInAlmostFull;
  logic procOutFull, procOutAlmostFull, procOutAlmostEmpty, procMbxIrq;
  logic mezzSel = 0, mezzDir = 1, mezzMbx = 0;
  logic [31:0] mezzWData = '0, mezzRData;
  logic mezzDataOe, mezzInFull, mezzInAlmostFull, mezzInAlmostEmpty;
  logic mezzOutEmpty, mezzOutAlmostEmpty, mezzOutAlmostFull, mezzMbxIrq;

  int checks = 0, fails = 0;
  logic [31:0] inQ[$], outQ[$];
  logic [31:0] lastMezz = '0;

  always #2.5 procClk = ~procClk;   // 200 MHz
  always #3.5 mezzClk = ~mezzClk;   // unrelated mezzanine clock

  bififo_mbx u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string req);
    chk(act === exp, req, 32'(act), 32'(exp));
  endtask

  task automatic settle();
    repeat (8) @(negedge mezzClk);
    repeat (8) @(negedge procClk);
  endtask

  task automatic mezzOp(input logic sel, input logic dir, input logic mbx, input logic [31:0] d);
    @(negedge mezzClk);
    mezzSel = sel; mezzDir = dir; mezzMbx = mbx; mezzWData = d;
    @(negedge mezzClk);
    mezzSel = 0; mezzDir = 1; mezzMbx = 0;
  endtask

  task automatic procOp(input logic fw, input logic fr, input logic mw, input logic mr,
                        input logic cw, input logic cs, input logic [31:0] d);
    @(negedge procClk);
    procFifoWr = fw; procFifoRd = fr; procMbxWr = mw; procMbxRd = mr;
    procCfgWr = cw; procCfgSel = cs; procWData = d;
    @(negedge procClk);
    procFifoWr = 0; procFifoRd = 0; procMbxWr = 0; procMbxRd = 0; procCfgWr = 0;
  endtask

  task automatic mezzPush(input logic [31:0] d);
    mezzOp(1, 1, 0, d);
    if (inQ.size() < 64) inQ.push_back(d);
  endtask

  task automatic procPush(input logic [31:0] d);
    procOp(1, 0, 0, 0, 0, 0, d);
    if (outQ.size() < 64) outQ.push_back(d);
  endtask

  task automatic procPop(input string req);
    logic [31:0] e;
    procOp(0, 1, 0, 0, 0, 0, '0);
    e = inQ.pop_front();
    chk(procRData === e, req, procRData, e);
  endtask

  task automatic mezzPop(input string req);
    mezzOp(1, 0, 0, '0);
    if (outQ.size() > 0) lastMezz = outQ.pop_front();
    chk(mezzRData === lastMezz, req, mezzRData, lastMezz);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge procClk);
    rstN = 1'b1;
    settle();
    // reset state (R10)
    chkBit(procInEmpty, 1, "R10 reset procInEmpty");
    chkBit(mezzOutEmpty, 1, "R10 reset mezzOutEmpty");
    chkBit(mezzInFull, 0, "R10 reset mezzInFull");
    chkBit(procMbxIrq, 0, "R10 reset procMbxIrq");
    chkBit(mezzMbxIrq, 0, "R10 reset mezzMbxIrq");

    // R1: inbound stream
    for (int i = 0; i < 10; i++) mezzPush(32'h1000_0000 + 32'(i * 7));
    settle();
    chkBit(procInEmpty, 0, "R1 inbound not empty");
    for (int i = 0; i < 10; i++) procPop("R1 inbound order");
    chkBit(procInEmpty, 1, "R1 inbound drained");

    // R2: outbound stream and bus enable
    for (int i = 0; i < 6; i++) procPush(32'hBEEF_0000 ^ 32'(i << 8));
    settle();
    @(negedge mezzClk); mezzDir = 0; #1;
    chkBit(mezzDataOe, 1, "R2 oe on read");
    mezzDir = 1; #1;
    chkBit(mezzDataOe, 0, "R2 oe off write");
    for (int i = 0; i < 6; i++) mezzPop("R2 outbound order");
    chkBit(mezzOutEmpty, 1, "R2 outbound drained");

    // R3: unselected edges do nothing
    settle();
    for (int i = 0; i < 5; i++) mezzOp(0, 1, 0, 32'hDEAD_0000 + 32'(i));
    procPush(32'h3333_0003);
    settle();
    mezzOp(0, 0, 0, '0);
    chk(mezzRData === lastMezz, "R3 rdata held", mezzRData, lastMezz);
    chkBit(mezzOutEmpty, 0, "R3 word still queued");
    chkBit(procInEmpty, 1, "R3 inbound untouched");
    mezzPop("R3 queued word intact");

    // R5: underflow keeps last word
    mezzPop("R5 underflow read");
    chkBit(mezzOutEmpty, 1, "R5 still empty");

    // R4 / R6: inbound fill
    settle();
    for (int i = 1; i <= 66; i++) begin
      mezzPush(32'h4400_0000 + 32'(i));
      if (i == 8)  chkBit(mezzInAlmostEmpty, 1, "R6 ae at 8");
      if (i == 9)  chkBit(mezzInAlmostEmpty, 0, "R6 ae off at 9");
      if (i == 55) chkBit(mezzInAlmostFull, 0, "R6 af off at 55");
      if (i == 56) chkBit(mezzInAlmostFull, 1, "R6 af at 56");
      if (i == 63) chkBit(mezzInFull, 0, "R4 not full at 63");
      if (i == 64) chkBit(mezzInFull, 1, "R4 full at 64");
    end
    settle();
    chkBit(procInAlmostFull, 1, "R6 proc sees af");
    chkBit(procInAlmostEmpty, 0, "R6 proc ae off");
    for (int i = 0; i < 64; i++) procPop("R4 drain after overflow");
    chkBit(procInEmpty, 1, "R4 exactly 64 stored");
    settle();
    chkBit(mezzInFull, 0, "R4 full cleared");

    // R7: threshold writes
    for (int i = 0; i < 10; i++) mezzPush(32'h7700_0000 + 32'(i));
    settle();
    chkBit(mezzInAlmostEmpty, 0, "R7 ae off at 10");
    procOp(0, 0, 0, 0, 1, 0, 32'd20);
    settle();
    chkBit(mezzInAlmostEmpty, 1, "R7 ae thr 20 mezz");
    chkBit(procInAlmostEmpty, 1, "R7 ae thr 20 proc");
    procOp(0, 0, 0, 0, 1, 1, 32'd60);
    settle();
    chkBit(mezzInAlmostFull, 1, "R7 af dist 60 mezz");
    chkBit(procInAlmostFull, 1, "R7 af dist 60 proc");
    procOp(0, 0, 0, 0, 1, 0, 32'd8);
    procOp(0, 0, 0, 0, 1, 1, 32'd8);
    settle();
    chkBit(mezzInAlmostFull, 0, "R7 af restored");
    for (int i = 0; i < 10; i++) procPop("R7 data undisturbed");

    // R8: mezzanine to processor mailbox
    mezzOp(1, 1, 1, 32'hA5A5_0801);
    settle();
    chkBit(procMbxIrq, 1, "R8 irq raised");
    chkBit(procInEmpty, 1, "R8 queue untouched");
    procOp(0, 0, 0, 1, 0, 0, '0);
    chk(procRData === 32'hA5A5_0801, "R8 mailbox word", procRData, 32'hA5A5_0801);
    chkBit(procMbxIrq, 0, "R8 irq cleared");

    // R9: processor to mezzanine mailbox
    procOp(0, 0, 1, 0, 0, 0, 32'h5A5A_0902);
    settle();
    chkBit(mezzMbxIrq, 1, "R9 irq raised");
    chkBit(mezzOutEmpty, 1, "R9 queue untouched");
    mezzOp(1, 0, 1, '0);
    chk(mezzRData === 32'h5A5A_0902, "R9 mailbox word", mezzRData, 32'h5A5A_0902);
    chkBit(mezzMbxIrq, 0, "R9 irq cleared");

    // R6 outbound thresholds, then R10 reset with data held
    for (int i = 1; i <= 56; i++) begin
      procPush(32'h6600_0000 + 32'(i));
      if (i == 55) chkBit(procOutAlmostFull, 0, "R6 out af off at 55");
      if (i == 56) chkBit(procOutAlmostFull, 1, "R6 out af at 56");
    end
    for (int i = 0; i < 5; i++) mezzPush(32'h9900_0000 + 32'(i));
    mezzOp(1, 1, 1, 32'h1234_5678);
    settle();
    chkBit(mezzOutAlmostFull, 1, "R6 mezz sees out af");
    chkBit(mezzOutAlmostEmpty, 0, "R6 mezz out ae off");
    @(negedge procClk); rstN = 1'b0;
    repeat (3) @(negedge procClk); rstN = 1'b1;
    inQ.delete(); outQ.delete();
    settle();
    chkBit(mezzOutEmpty, 1, "R10 outbound cleared");
    chkBit(procOutAlmostFull, 0, "R10 out af cleared");
    chkBit(procInEmpty, 1, "R10 inbound cleared");
    chkBit(mezzInAlmostEmpty, 1, "R10 inbound ae");
    chkBit(procMbxIrq, 0, "R10 irq cleared");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule